// File: doc/BRIEF.md
# Parallel Additive LFSR Scrambler

This block whitens a data stream by combining each input word with a pseudo-random keystream. A free-running Galois-form LFSR produces the keystream, and the data never feeds back into it. Each clock with a valid word handles DATA_W bits. That one clock gives the same result as DATA_W steps of a one-bit-per-step scrambler. Every output bit and every next-state bit is a fixed XOR of current-state bits. Those XOR sets are derived at elaboration from the block's response to each one-hot state.

The same circuit descrambles. A receiver that is reseeded at the same word of the stream as the transmitter recovers the original data. A synchronous reseed input returns the LFSR to all ones when a link synchronization symbol is seen. The word presented together with a reseed is scrambled from that fresh all-ones state.

By default the polynomial is x^16+x^5+x^4+x^3+1 and the word width is 8 bits. The parameters allow a wider word. A wider instance yields the same stream as a narrow one, with the earlier word in the lower bits.

Top module: `par_scrambler`

## Requirements
- R1: While rst_n is low, out_valid and out_data are 0 and the LFSR is set to all ones. The first valid word after reset is scrambled from the all-ones state.
- R2: out_data equals a bit-serial reference scrambler fed in_data bit 0 first. For each bit, the key k is state bit LFSR_W-1, the output is data^k, and the new state is (state<<1) XOR (k ? TAPS : 0). TAPS holds the non-leading polynomial terms, 16'h0039 by default.
- R3: The keystream (out_data XOR in_data) depends only on the seed and the number of words, never on the data values.
- R4: On a clock with in_valid low and reseed low, the LFSR state does not change.
- R5: When reseed and in_valid are both high, the word is scrambled with the all-ones state. The LFSR then continues from the all-ones state advanced by one word.
- R6: When reseed is high and in_valid is low, the LFSR becomes all ones and no output word is produced.
- R7: out_valid equals in_valid delayed by one clock. out_data changes only after a clock on which in_valid was high.
- R8: Feeding the scrambled words back through the block after an identical reseed returns the original words.
- R9: An instance with DATA_W=16, fed {word1,word0}, gives {out1,out0} from an 8-bit instance fed word0 then word1 from the same seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_data holds a word to scramble |
| in_data | input | DATA_W | Input word, bit 0 earliest |
| reseed | input | 1 | Force the LFSR to all ones (sync symbol) |
| out_valid | output | 1 | out_data holds a new word |
| out_data | output | DATA_W | Scrambled word |

## Verification
A wrong LFSR state shows at the ports on the very next valid word: out_data XOR in_data no longer matches the serial reference keystream. Because the state never recovers without a reseed, every later word also stays wrong. A wrong reseed or hold decision therefore shows one clock after the next valid word is presented, however long the idle gap before it. Width-dependent matrix errors show only as a mismatch between the 8-bit and 16-bit instances, so both are run side by side from a common seed.

// File: rtl/par_scrambler.sv
module par_scrambler #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 'h0039
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reseed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam logic [LFSR_W-1:0] SEED = '1;
  localparam int RW = LFSR_W + DATA_W;

  function automatic logic [RW-1:0] word_resp(input logic [LFSR_W-1:0] s0);
    logic [LFSR_W-1:0] s;
    logic [DATA_W-1:0] k;
    s = s0;
    k = '0;
    for (int i = 0; i < DATA_W; i++) begin
      k[i] = s[LFSR_W-1];
      s = {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? TAPS : '0);
    end
    return {s, k};
  endfunction

  logic [LFSR_W-1:0] state, base, nxt;
  logic [DATA_W-1:0] key;
  logic [RW-1:0]     term [LFSR_W];
  logic [RW-1:0]     acc;

  assign base = reseed ? SEED : state;

  for (genvar c = 0; c < LFSR_W; c++) begin : g_col
    localparam logic [RW-1:0] COL = word_resp(LFSR_W'(1) << c);
    assign term[c] = base[c] ? COL : '0;
  end

  always_comb begin
    acc = '0;
    for (int c = 0; c < LFSR_W; c++) acc = acc ^ term[c];
  end
  assign {nxt, key} = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEED;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        state    <= nxt;
        out_data <= in_data ^ key;
      end else if (reseed) begin
        state <= SEED;
      end
    end
  end
endmodule

// File: rtl/par_scrambler_chk.sv
module par_scrambler_chk #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 'h0039
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              reseed,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [LFSR_W-1:0] state
);
  function automatic logic [DATA_W-1:0] serial_key(input logic [LFSR_W-1:0] s0);
    logic [LFSR_W-1:0] s;
    logic [DATA_W-1:0] k;
    s = s0;
    k = '0;
    for (int i = 0; i < DATA_W; i++) begin
      k[i] = s[LFSR_W-1];
      if (s[LFSR_W-1]) s = (s << 1) ^ TAPS;
      else s = s << 1;
    end
    return k;
  endfunction

  localparam logic [DATA_W-1:0] KEY_ONES = serial_key('1);

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !reseed) |=> $stable(state));
  p_reseed_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed && !in_valid) |=> state == '1);
  p_reseed_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed && in_valid) |=> out_data == ($past(in_data) ^ KEY_ONES));
  p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

bind par_scrambler par_scrambler_chk #(.DATA_W(DATA_W), .LFSR_W(LFSR_W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .reseed(reseed),
  .out_valid(out_valid), .out_data(out_data), .state(state));

// File: tb/tb_par_scrambler.sv
`timescale 1ns/1ps
module tb_par_scrambler;
  logic clk = 0, rst_n = 0;
  logic v = 0, rs = 0, ov;
  logic [7:0] d = 0, od;
  logic wv = 0, wrs = 0, wov;
  logic [15:0] wd = 0, wod;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] ms;
  logic [7:0] exp8;

  always #10 clk = ~clk;

  par_scrambler dut (.clk(clk), .rst_n(rst_n), .in_valid(v), .in_data(d), .reseed(rs),
                     .out_valid(ov), .out_data(od));
  par_scrambler #(.DATA_W(16)) dut_w (.clk(clk), .rst_n(rst_n), .in_valid(wv), .in_data(wd),
                     .reseed(wrs), .out_valid(wov), .out_data(wod));

  function automatic logic [31:0] ser(input logic [15:0] s, input logic [15:0] x, input int n);
    logic [15:0] o = '0;
    for (int i = 0; i < n; i++) begin
      logic k = s[15];
      o[i] = x[i] ^ k;
      s = {s[14:0], 1'b0} ^ (k ? 16'h0039 : 16'h0000);
    end
    return {s, o};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic word(input logic iv, input logic ir, input logic [7:0] x);
    logic [31:0] r;
    @(negedge clk);
    v = iv; rs = ir; d = x;
    @(posedge clk); #2;
    v = 0; rs = 0;
    if (ir) ms = 16'hFFFF;
    if (iv) begin r = ser(ms, {8'h0, x}, 8); ms = r[31:16]; exp8 = r[7:0]; end
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {15'h0, ov}, 16'h0);
    chk("R1 out_data", {8'h0, od}, 16'h0);
    rst_n = 1; ms = 16'hFFFF;
    word(1, 0, 8'h00);
    chk("R1 first word", {8'h0, od}, {8'h0, exp8});
    chk("R7 valid after word", {15'h0, ov}, 16'h1);
  endtask

  task automatic t_serial;
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
    foreach (pats[i]) begin
      word(1, 0, pats[i]);
      chk("R2 serial match", {8'h0, od}, {8'h0, exp8});
    end
  endtask

  task automatic t_hold;
    logic [7:0] last;
    last = od;
    word(0, 0, 8'h5A);
    chk("R7 no valid", {15'h0, ov}, 16'h0);
    chk("R7 data held", {8'h0, od}, {8'h0, last});
    repeat (5) word(0, 0, 8'hC3);
    word(1, 0, 8'h77);
    chk("R4 state held over idle", {8'h0, od}, {8'h0, exp8});
  endtask

  task automatic t_reseed;
    word(1, 0, 8'h11);
    word(1, 1, 8'h22);
    chk("R5 reseed with word", {8'h0, od}, {8'h0, exp8});
    word(1, 0, 8'h33);
    chk("R5 continue after reseed", {8'h0, od}, {8'h0, exp8});
    word(0, 1, 8'h44);
    chk("R6 no output on idle reseed", {15'h0, ov}, 16'h0);
    word(1, 0, 8'h55);
    chk("R6 word after idle reseed", {8'h0, od}, {8'h0, exp8});
  endtask

  task automatic t_indep;
    logic [7:0] ks [4];
    logic [7:0] dat [4] = '{8'h9E, 8'h00, 8'hFF, 8'h6B};
    word(0, 1, 8'h0);
    for (int i = 0; i < 4; i++) begin word(1, 0, 8'h00); ks[i] = od; end
    word(0, 1, 8'h0);
    for (int i = 0; i < 4; i++) begin
      word(1, 0, dat[i]);
      chk("R3 keystream data-independent", {8'h0, od ^ dat[i]}, {8'h0, ks[i]});
    end
  endtask

  task automatic t_descramble;
    logic [7:0] a [5] = '{8'h48, 8'h65, 8'h6C, 8'h00, 8'hFE};
    logic [7:0] b [5];
    word(0, 1, 8'h0);
    for (int i = 0; i < 5; i++) begin word(1, 0, a[i]); b[i] = od; end
    word(0, 1, 8'h0);
    for (int i = 0; i < 5; i++) begin
      word(1, 0, b[i]);
      chk("R8 descramble restores", {8'h0, od}, {8'h0, a[i]});
    end
  endtask

  task automatic t_wide;
    logic [7:0] o0;
    @(negedge clk); v = 0; rs = 1; wv = 0; wrs = 1;
    @(posedge clk); #2; rs = 0; wrs = 0; ms = 16'hFFFF;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] b0, b1;
      b0 = 8'h1F * j + 8'h07; b1 = 8'hB2 ^ 8'(j);
      @(negedge clk); v = 1; d = b0; wv = 1; wd = {b1, b0};
      @(posedge clk); #2; v = 0; wv = 0; o0 = od;
      @(negedge clk); v = 1; d = b1;
      @(posedge clk); #2; v = 0;
      chk("R9 wide equals two narrow", wod, {od, o0});
      chk("R9 wide equals serial", wod, ser(ms, {b1, b0}, 16) & 16'hFFFF);
      ms = ser(ms, {b1, b0}, 16) >> 16;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_serial();
    t_hold();
    t_reseed();
    t_indep();
    t_descramble();
    t_wide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule